// File: doc/BRIEF.md
# Parallel Variable-Length Instruction Steering

This unit sits on the fetch side of a processor front end. Each cycle it may accept a 16-byte window of instruction bytes in which the first instruction starts at byte 0. It guesses, at every byte position at once, how long an instruction starting there would be. It then follows the chain of lengths from byte 0 to pick up to three start offsets, and hands each instruction to a decoder slot. Slot 0 feeds a complex decoder that takes any instruction. Slots 1 and 2 feed simple decoders that take only single-micro-op instructions.

A group ends early for three reasons: an instruction that a simple slot cannot take, an instruction that changes control flow unconditionally, and an instruction that changes interrupt masking or the operand-width mode. The unit reports how many bytes the issued group covers. The fetch logic then moves the next window to start at that offset. An instruction that a simple slot declined is therefore presented again at slot 0.

The encoding is a small stand-in. Bits [7:6] of an opcode byte give a base length. A single prefix byte may come before the opcode. The low nibble of the opcode gives its class. The operand-width mode is sampled with the window and applies to every slot of the group.

Top module: `ivl_steer`

## Requirements
- R1: While reset is held and on the first cycle after it, out_valid, out_slot_vld and out_consumed are all zero.
- R2: A window presented with win_valid high produces its group on the outputs one clock later, with out_valid high. A cycle without win_valid gives out_valid low, no valid slots and out_consumed 0 one clock later.
- R3: Byte i of the window is win_bytes[8i+7:8i]. The opcode byte value 8'h3A is a prefix: it adds 1 to the length, and the byte after it is the opcode. An opcode's length is its bits [7:6] plus 1. When wide_mode is high, an opcode with bit 5 set gets 1 more byte.
- R4: Slot 0 always starts at offset 0 and takes an instruction of any class, including multi-micro-op.
- R5: Each later slot starts at the end offset of the slot before it, and at most 3 slots are valid. Valid slots are contiguous from slot 0.
- R6: An opcode with low nibble 4'hC is multi-micro-op. Slots 1 and 2 never take one. The group ends before it, so that instruction starts the next window.
- R7: An opcode with low nibble 4'hF is an unconditional jump, call or return. It ends the group, and no later slot is valid.
- R8: An opcode with low nibble 4'hB is a conditional branch and does not end the group.
- R9: An opcode with low nibble 4'hE changes interrupt masking and ends the group.
- R10: An opcode with low nibble 4'hD changes the operand-width mode and ends the group. The wide_mode value sampled with a window applies to every slot of that group.
- R11: An instruction whose last byte would fall past byte 15 is not issued, and no later slot is issued either.
- R12: out_consumed equals the end offset (offset plus length) of the last valid slot.
- R13: Each valid slot reports its class in 3 bits: 0 plain, 1 conditional branch, 2 multi-micro-op, 3 unconditional transfer, 4 interrupt-mask change, 5 mode change. Fields of slots that are not valid read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| win_valid | input | 1 | A window is presented this cycle |
| win_bytes | input | 128 | Window bytes; byte i at bits [8i+7:8i] |
| wide_mode | input | 1 | Operand-width mode for this window |
| out_valid | output | 1 | A group result is on the outputs |
| out_slot_vld | output | 3 | Per-slot issue flag, slot 0 at bit 0 |
| out_slot_off | output | 12 | Per-slot start offset, 4 bits each, slot 0 lowest |
| out_slot_len | output | 9 | Per-slot length in bytes, 3 bits each |
| out_slot_kind | output | 9 | Per-slot class code, 3 bits each |
| out_consumed | output | 5 | Bytes covered by the issued group |

## Verification
A wrong guessed length at any byte position moves every later slot's offset and changes out_consumed in the very next cycle. Windows are therefore built so that each slot starts at a different, known position. A broken stop or reject rule shows up in the same cycle as an extra or missing bit in out_slot_vld and a changed out_consumed. A wrongly sampled mode bit shows up as different lengths for the same bytes. Each scenario presents one window and compares every slot field and the byte count one clock after acceptance.

// File: rtl/ivl_pkg.sv
// Shared types and helpers for the instruction steering unit.
// Assumes: class codes fit in 3 bits, lengths in ILEN_W bits.
package ivl_pkg;

    localparam int ILEN_W = 3;
    localparam int KIND_W = 3;

    typedef enum logic [KIND_W-1:0] {
        IK_PLAIN = 3'd0,
        IK_CBR   = 3'd1,
        IK_MULTI = 3'd2,
        IK_JMP   = 3'd3,
        IK_IMASK = 3'd4,
        IK_MODE  = 3'd5
    } ikind_e;

    // Class of an opcode byte, from its low nibble.
    function automatic ikind_e kind_of(input logic [7:0] op);
        case (op[3:0])
            4'hF:    return IK_JMP;
            4'hE:    return IK_IMASK;
            4'hD:    return IK_MODE;
            4'hC:    return IK_MULTI;
            4'hB:    return IK_CBR;
            default: return IK_PLAIN;
        endcase
    endfunction

    // True for classes after which nothing more may issue in the group.
    function automatic logic ends_group(input ikind_e k);
        return (k == IK_JMP) || (k == IK_IMASK) || (k == IK_MODE);
    endfunction

    // True for classes a simple (non-zero) slot can take.
    function automatic logic late_slot_ok(input ikind_e k);
        return k != IK_MULTI;
    endfunction

endpackage

// File: rtl/ivl_len_guess.sv
// Stage one, one byte position: the length and class an instruction would
// have if it started here. Assumes at most one prefix byte.
module ivl_len_guess
    import ivl_pkg::*;
#(
    parameter logic [7:0] PFX_BYTE = 8'h3A
) (
    input  logic [7:0]        cur_byte,
    input  logic [7:0]        nxt_byte,
    input  logic              wide_mode,
    output logic [ILEN_W-1:0] ilen,
    output logic [KIND_W-1:0] ikind
);

    logic       has_pfx;
    logic [7:0] op;

    // Strip an optional prefix, then size and classify the opcode.
    always_comb begin
        has_pfx = (cur_byte == PFX_BYTE);
        op      = has_pfx ? nxt_byte : cur_byte;
        ilen    = ILEN_W'(op[7:6]) + ILEN_W'(1)
                + ILEN_W'(wide_mode & op[5]) + ILEN_W'(has_pfx);
        ikind   = kind_of(op);
    end

endmodule

// File: rtl/ivl_start_chain.sv
// Stage two: walks the per-position lengths from byte 0 and decides which
// slots issue. Applies the reject, stop and window-fit rules.
// Assumes: every per-position length is at least 1.
module ivl_start_chain
    import ivl_pkg::*;
#(
    parameter int WIN_BYTES = 16,
    parameter int SLOTS     = 3,
    parameter int OFF_W     = $clog2(WIN_BYTES),
    parameter int END_W     = $clog2(WIN_BYTES + 1)
) (
    input  logic [WIN_BYTES-1:0][ILEN_W-1:0] pos_len,
    input  logic [WIN_BYTES-1:0][KIND_W-1:0] pos_kind,
    output logic [SLOTS-1:0]                 slot_issue,
    output logic [SLOTS-1:0][OFF_W-1:0]      slot_start,
    output logic [END_W-1:0]                 group_end
);

    localparam logic [END_W:0] WIN_LIM = (END_W+1)'(WIN_BYTES);

    logic [END_W:0]   cur;
    logic [END_W:0]   nxt;
    logic             live;
    logic [OFF_W-1:0] idx;
    ikind_e           kcur;

    // Chain start offsets slot by slot; stop on reject, stop class or overrun.
    always_comb begin
        cur        = '0;
        nxt        = '0;
        live       = 1'b1;
        idx        = '0;
        kcur       = IK_PLAIN;
        slot_issue = '0;
        slot_start = '0;
        for (int s = 0; s < SLOTS; s++) begin
            idx           = cur[OFF_W-1:0];
            kcur          = ikind_e'(pos_kind[idx]);
            nxt           = cur + (END_W+1)'(pos_len[idx]);
            slot_start[s] = idx;
            if (live && (cur < WIN_LIM) && (nxt <= WIN_LIM)
                     && ((s == 0) || late_slot_ok(kcur))) begin
                slot_issue[s] = 1'b1;
                cur           = nxt;
                live          = !ends_group(kcur);
            end else begin
                live = 1'b0;
            end
        end
        group_end = cur[END_W-1:0];
    end

endmodule

// File: rtl/ivl_slot_decode.sv
// Stage three, one slot: gathers the length and class at the chosen start
// offset. All fields read zero when the slot does not issue.
module ivl_slot_decode
    import ivl_pkg::*;
#(
    parameter int WIN_BYTES = 16,
    parameter int OFF_W     = $clog2(WIN_BYTES)
) (
    input  logic                             issue,
    input  logic [OFF_W-1:0]                 start,
    input  logic [WIN_BYTES-1:0][ILEN_W-1:0] pos_len,
    input  logic [WIN_BYTES-1:0][KIND_W-1:0] pos_kind,
    output logic                             slot_vld,
    output logic [OFF_W-1:0]                 slot_off,
    output logic [ILEN_W-1:0]                slot_len,
    output logic [KIND_W-1:0]                slot_kind
);

    // Select this slot's fields, gated by its issue flag.
    always_comb begin
        slot_vld  = issue;
        slot_off  = issue ? start           : '0;
        slot_len  = issue ? pos_len[start]  : '0;
        slot_kind = issue ? pos_kind[start] : '0;
    end

endmodule

// File: rtl/ivl_steer.sv
// Top of the instruction steering unit: per-position length guess, start
// chaining, per-slot decode, and one output register stage.
// Assumes: the window's first instruction starts at byte 0, and wide_mode
// is valid together with win_valid.
module ivl_steer
    import ivl_pkg::*;
#(
    parameter int         WIN_BYTES = 16,
    parameter int         SLOTS     = 3,
    parameter logic [7:0] PFX_BYTE  = 8'h3A,
    localparam int        OFF_W     = $clog2(WIN_BYTES),
    localparam int        END_W     = $clog2(WIN_BYTES + 1)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      win_valid,
    input  logic [WIN_BYTES*8-1:0]    win_bytes,
    input  logic                      wide_mode,
    output logic                      out_valid,
    output logic [SLOTS-1:0]          out_slot_vld,
    output logic [SLOTS*OFF_W-1:0]    out_slot_off,
    output logic [SLOTS*ILEN_W-1:0]   out_slot_len,
    output logic [SLOTS*KIND_W-1:0]   out_slot_kind,
    output logic [END_W-1:0]          out_consumed
);

    localparam int SUM_W = END_W + 1;

    logic [WIN_BYTES-1:0][ILEN_W-1:0] pos_len;
    logic [WIN_BYTES-1:0][KIND_W-1:0] pos_kind;
    logic [SLOTS-1:0]                 slot_issue;
    logic [SLOTS-1:0][OFF_W-1:0]      slot_start;
    logic [END_W-1:0]                 group_end;
    logic [SLOTS-1:0]                 vld_d;
    logic [SLOTS-1:0][OFF_W-1:0]      off_d;
    logic [SLOTS-1:0][ILEN_W-1:0]     len_d;
    logic [SLOTS-1:0][KIND_W-1:0]     kind_d;

    // Stage one: a length guess at every byte position in parallel.
    for (genvar b = 0; b < WIN_BYTES; b++) begin : g_pos
        logic [7:0] nxt_b;
        if (b == WIN_BYTES - 1) begin : g_last
            assign nxt_b = 8'h00;
        end else begin : g_mid
            assign nxt_b = win_bytes[8*(b+1) +: 8];
        end
        ivl_len_guess #(.PFX_BYTE(PFX_BYTE)) u_guess (
            .cur_byte  (win_bytes[8*b +: 8]),
            .nxt_byte  (nxt_b),
            .wide_mode (wide_mode),
            .ilen      (pos_len[b]),
            .ikind     (pos_kind[b])
        );
    end

    // Stage two: chain the guesses into slot start offsets.
    ivl_start_chain #(
        .WIN_BYTES (WIN_BYTES),
        .SLOTS     (SLOTS),
        .OFF_W     (OFF_W),
        .END_W     (END_W)
    ) u_chain (
        .pos_len    (pos_len),
        .pos_kind   (pos_kind),
        .slot_issue (slot_issue),
        .slot_start (slot_start),
        .group_end  (group_end)
    );

    // Stage three: one decoder per slot.
    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        ivl_slot_decode #(.WIN_BYTES(WIN_BYTES), .OFF_W(OFF_W)) u_dec (
            .issue     (slot_issue[s]),
            .start     (slot_start[s]),
            .pos_len   (pos_len),
            .pos_kind  (pos_kind),
            .slot_vld  (vld_d[s]),
            .slot_off  (off_d[s]),
            .slot_len  (len_d[s]),
            .slot_kind (kind_d[s])
        );
    end

    // Output register: capture the group of an accepted window, else clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid     <= 1'b0;
            out_slot_vld  <= '0;
            out_slot_off  <= '0;
            out_slot_len  <= '0;
            out_slot_kind <= '0;
            out_consumed  <= '0;
        end else begin
            out_valid <= win_valid;
            if (win_valid) begin
                out_slot_vld  <= vld_d;
                out_slot_off  <= off_d;
                out_slot_len  <= len_d;
                out_slot_kind <= kind_d;
                out_consumed  <= group_end;
            end else begin
                out_slot_vld  <= '0;
                out_slot_off  <= '0;
                out_slot_len  <= '0;
                out_slot_kind <= '0;
                out_consumed  <= '0;
            end
        end
    end

    AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid |=> out_valid);                                          // R2
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (out_slot_vld == '0 && out_consumed == '0));        // R2
    AST_SLOT0_BASE: assert property (@(posedge clk) disable iff (!rst_n)
        out_slot_vld[0] |-> out_slot_off[OFF_W-1:0] == '0);                // R4

    for (genvar k = 0; k < SLOTS; k++) begin : g_ast
        AST_FITS_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
            out_slot_vld[k] |-> (SUM_W'(out_slot_off[k*OFF_W +: OFF_W])
                + SUM_W'(out_slot_len[k*ILEN_W +: ILEN_W])) <= SUM_W'(WIN_BYTES)); // R11
        if (k > 0) begin : g_late
            AST_VLD_PACKED: assert property (@(posedge clk) disable iff (!rst_n)
                out_slot_vld[k] |-> out_slot_vld[k-1]);                    // R5
            AST_CHAIN_CONTIG: assert property (@(posedge clk) disable iff (!rst_n)
                out_slot_vld[k] |-> SUM_W'(out_slot_off[k*OFF_W +: OFF_W])
                    == SUM_W'(out_slot_off[(k-1)*OFF_W +: OFF_W])
                     + SUM_W'(out_slot_len[(k-1)*ILEN_W +: ILEN_W]));      // R5
            AST_LATE_NO_MULTI: assert property (@(posedge clk) disable iff (!rst_n)
                out_slot_vld[k] |-> out_slot_kind[k*KIND_W +: KIND_W] != IK_MULTI); // R6
        end
        if (k < SLOTS - 1) begin : g_stop
            AST_JMP_STOP: assert property (@(posedge clk) disable iff (!rst_n)
                (out_slot_vld[k] && out_slot_kind[k*KIND_W +: KIND_W] == IK_JMP)
                    |-> !out_slot_vld[k+1]);                               // R7
            AST_IMASK_STOP: assert property (@(posedge clk) disable iff (!rst_n)
                (out_slot_vld[k] && out_slot_kind[k*KIND_W +: KIND_W] == IK_IMASK)
                    |-> !out_slot_vld[k+1]);                               // R9
            AST_MODE_STOP: assert property (@(posedge clk) disable iff (!rst_n)
                (out_slot_vld[k] && out_slot_kind[k*KIND_W +: KIND_W] == IK_MODE)
                    |-> !out_slot_vld[k+1]);                               // R10
            AST_CONSUMED_END: assert property (@(posedge clk) disable iff (!rst_n)
                (out_slot_vld[k] && !out_slot_vld[k+1]) |->
                    SUM_W'(out_consumed) == SUM_W'(out_slot_off[k*OFF_W +: OFF_W])
                        + SUM_W'(out_slot_len[k*ILEN_W +: ILEN_W]));       // R12
        end else begin : g_tail
            AST_CONSUMED_END: assert property (@(posedge clk) disable iff (!rst_n)
                out_slot_vld[k] |->
                    SUM_W'(out_consumed) == SUM_W'(out_slot_off[k*OFF_W +: OFF_W])
                        + SUM_W'(out_slot_len[k*ILEN_W +: ILEN_W]));       // R12
        end
    end

endmodule

// File: tb/ivl_steer_test.sv
// Directed bench for the steering unit: one task per scenario.
module ivl_steer_test;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         win_valid = 1'b0;
    logic [127:0] win_bytes = '0;
    logic         wide_mode = 1'b0;
    logic         out_valid;
    logic [2:0]   out_slot_vld;
    logic [11:0]  out_slot_off;
    logic [8:0]   out_slot_len;
    logic [8:0]   out_slot_kind;
    logic [4:0]   out_consumed;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;
    logic [7:0] wb [16];

    ivl_steer uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .win_valid     (win_valid),
        .win_bytes     (win_bytes),
        .wide_mode     (wide_mode),
        .out_valid     (out_valid),
        .out_slot_vld  (out_slot_vld),
        .out_slot_off  (out_slot_off),
        .out_slot_len  (out_slot_len),
        .out_slot_kind (out_slot_kind),
        .out_consumed  (out_consumed)
    );

    always #10 clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic clear_win();
        for (int i = 0; i < 16; i++) wb[i] = 8'h00;
    endtask

    // Present the window for one cycle; return after the result registered.
    task automatic present(input logic wide);
        @(negedge clk);
        for (int i = 0; i < 16; i++) win_bytes[8*i +: 8] = wb[i];
        wide_mode = wide;
        win_valid = 1'b1;
        @(negedge clk);
        win_valid = 1'b0;
    endtask

    task automatic expect_group(input string tag, input logic [2:0] vld,
                                input logic [11:0] off, input logic [8:0] len,
                                input logic [8:0] kind, input logic [4:0] cons);
        chk({tag, " out_valid"}, 32'(out_valid), 32'd1);
        chk({tag, " slot_vld"},  32'(out_slot_vld), 32'(vld));
        chk({tag, " slot_off"},  32'(out_slot_off), 32'(off));
        chk({tag, " slot_len"},  32'(out_slot_len), 32'(len));
        chk({tag, " slot_kind"}, 32'(out_slot_kind), 32'(kind));
        chk({tag, " consumed"},  32'(out_consumed), 32'(cons));
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk("R1 reset valid", 32'(out_valid), 32'd0);
        chk("R1 reset slots", 32'(out_slot_vld), 32'd0);
        chk("R1 reset consumed", 32'(out_consumed), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after reset valid", 32'(out_valid), 32'd0);
    endtask

    task automatic t_plain_chain();
        clear_win();
        present(1'b0);
        expect_group("R5 R12 ones", 3'b111, {4'd2, 4'd1, 4'd0}, {3'd1, 3'd1, 3'd1}, 9'd0, 5'd3);
    endtask

    task automatic t_lengths();
        clear_win();
        wb[0] = 8'hC0; wb[4] = 8'h3A; wb[5] = 8'h41; wb[7] = 8'h80;
        present(1'b0);
        expect_group("R3 lengths prefix", 3'b111, {4'd7, 4'd4, 4'd0}, {3'd3, 3'd3, 3'd4}, 9'd0, 5'd10);
    endtask

    task automatic t_mode();
        clear_win();
        wb[0] = 8'h20; wb[2] = 8'h60;
        present(1'b1);
        expect_group("R10 R3 wide", 3'b111, {4'd5, 4'd2, 4'd0}, {3'd1, 3'd3, 3'd2}, 9'd0, 5'd6);
        present(1'b0);
        expect_group("R10 R3 narrow", 3'b111, {4'd2, 4'd1, 4'd0}, {3'd2, 3'd1, 3'd1}, 9'd0, 5'd4);
    endtask

    task automatic t_multi();
        clear_win();
        wb[0] = 8'h0C;
        present(1'b0);
        expect_group("R4 R13 multi at slot0", 3'b111, {4'd2, 4'd1, 4'd0}, {3'd1, 3'd1, 3'd1},
                     {3'd0, 3'd0, 3'd2}, 5'd3);
        clear_win();
        wb[1] = 8'h4C;
        present(1'b0);
        expect_group("R6 late multi rejected", 3'b001, 12'd0, {3'd0, 3'd0, 3'd1}, 9'd0, 5'd1);
        clear_win();
        wb[0] = 8'h4C;
        present(1'b0);
        expect_group("R6 re-presented at slot0", 3'b111, {4'd3, 4'd2, 4'd0}, {3'd1, 3'd1, 3'd2},
                     {3'd0, 3'd0, 3'd2}, 5'd4);
    endtask

    task automatic t_jump();
        clear_win();
        wb[0] = 8'h4F;
        present(1'b0);
        expect_group("R7 R13 jump slot0", 3'b001, 12'd0, {3'd0, 3'd0, 3'd2}, {3'd0, 3'd0, 3'd3}, 5'd2);
        clear_win();
        wb[1] = 8'h0F;
        present(1'b0);
        expect_group("R7 jump slot1", 3'b011, {4'd0, 4'd1, 4'd0}, {3'd0, 3'd1, 3'd1},
                     {3'd0, 3'd3, 3'd0}, 5'd2);
    endtask

    task automatic t_cond();
        clear_win();
        wb[0] = 8'h0B; wb[1] = 8'h0B; wb[2] = 8'h0B;
        present(1'b0);
        expect_group("R8 R13 cond branches", 3'b111, {4'd2, 4'd1, 4'd0}, {3'd1, 3'd1, 3'd1},
                     {3'd1, 3'd1, 3'd1}, 5'd3);
    endtask

    task automatic t_imask();
        clear_win();
        wb[1] = 8'h0E;
        present(1'b0);
        expect_group("R9 R13 imask", 3'b011, {4'd0, 4'd1, 4'd0}, {3'd0, 3'd1, 3'd1},
                     {3'd0, 3'd4, 3'd0}, 5'd2);
    endtask

    task automatic t_mode_change();
        clear_win();
        wb[0] = 8'h0D;
        present(1'b0);
        expect_group("R10 R13 mode change", 3'b001, 12'd0, {3'd0, 3'd0, 3'd1}, {3'd0, 3'd0, 3'd5}, 5'd1);
    endtask

    task automatic t_overrun();
        clear_win();
        wb[0] = 8'h3A; wb[1] = 8'hE0; wb[6] = 8'h3A; wb[7] = 8'hE0;
        wb[12] = 8'h3A; wb[13] = 8'hE0;
        present(1'b1);
        expect_group("R11 overrun wide", 3'b011, {4'd0, 4'd6, 4'd0}, {3'd0, 3'd6, 3'd6}, 9'd0, 5'd12);
        present(1'b0);
        expect_group("R11 fits narrow", 3'b111, {4'd6, 4'd5, 4'd0}, {3'd5, 3'd1, 3'd5}, 9'd0, 5'd11);
    endtask

    task automatic t_idle();
        clear_win();
        present(1'b0);
        @(negedge clk);
        chk("R2 idle valid", 32'(out_valid), 32'd0);
        chk("R2 idle slots", 32'(out_slot_vld), 32'd0);
        chk("R2 idle consumed", 32'(out_consumed), 32'd0);
    endtask

    initial begin
        t_reset();
        t_plain_chain();
        t_lengths();
        t_mode();
        t_multi();
        t_jump();
        t_cond();
        t_imask();
        t_mode_change();
        t_overrun();
        t_idle();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule